// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Bank

This block holds the control and status registers of a 32-bit RISC-V hart that runs only at the machine privilege level, with an extra debug level. It covers the floating-point control word, machine status, interrupt enable and pending, trap vector, trap program counter, trap cause, trap value, debug control, debug program counter and the four read-only identity words. Fields that belong to supervisor or user levels are not stored: they read as zero and drop writes. The block also decides whether an access is legal and raises an illegal-instruction flag when it is not.

Accesses arrive as a valid/ready request stream carrying a 12-bit address, a 2-bit operation, write data and the current debug flag. Each accepted request produces one response beat carrying the old register value and the illegal flag. `req_ready` is high when the response slot is empty, or when it is being drained in the same cycle (`rsp_ready` high). A response stays on the outputs, unchanged, until the consumer takes it. A separate trap port loads the trap program counter, cause and value in one cycle. The three interrupt inputs and the platform interrupt bus are shown live through the pending register.

Top module: `hart_csr_bank`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, with `req_ready` = `!rsp_valid || rsp_ready`. The response appears one cycle after acceptance and is held stable while `rsp_valid` is high and `rsp_ready` is low.
- R2: `req_op` 00 reads, 01 writes `req_wdata`, 10 sets the bits given in `req_wdata`, and 11 clears them. Set and clear act on the current value. The response always returns the value held before the access.
- R3: Address 0x003 shows the floating-point word, with the rounding mode in [7:5], the accrued flags in [4:0] (NV, DZ, OF, UF, NX from bit 4 down to bit 0) and zero above. Address 0x001 reads and writes only the flags, in [4:0]. Address 0x002 reads and writes only the rounding mode, in [2:0]. All three share one storage.
- R4: The only legal rounding mode is 000. A write at 0x002 or 0x003 that would leave another mode is illegal, and the floating-point word keeps all of its bits.
- R5: The machine status register (0x300) stores only bit 3 (global enable), bit 7 (previous enable), bits 12:11 (previous level) and bits 14:13 (float state). Every other bit reads zero, except bit 31, which is read-only and reads 1 exactly when bits 14:13 are 11.
- R6: The interrupt-enable register (0x304) stores bits 31:16, 11, 7 and 3. All other bits read zero.
- R7: The pending register (0x344) reads `plat_irq` in 31:16, `irq_ext` in bit 11, `irq_tmr` in bit 7 and `irq_sw` in bit 3, with the rest zero. Writes to it are legal and have no effect.
- R8: The trap vector (0x305), trap cause (0x342) and trap value (0x343) store all 32 bits. The trap program counter (0x341) always reads bits 1:0 as zero.
- R9: When `trap_valid` is high at a rising edge, the trap program counter takes `trap_epc` with bits 1:0 cleared, the cause takes `trap_cause` and the value takes `trap_tval`. The trap load wins over a CSR write to the same register in that cycle.
- R10: Addresses 0x7B0 (debug control) and 0x7B1 (debug PC) are illegal unless `dbg_mode` is high, and an illegal access leaves them unchanged. Debug control stores bits 15, 11, 10, 9 and 2, reads bits 31:28 as 4 and bits 1:0 as 11, and reads all other bits as zero. Debug PC reads bit 0 as zero.
- R11: Addresses 0xF11, 0xF12, 0xF13 and 0xF14 return the parameters VENDOR_ID, ARCH_ID, IMPL_ID and HART_ID. Any operation other than read on them is illegal.
- R12: An access to any other address is illegal. An illegal response carries zero read data and changes no register.
- R13: After reset, every stored field is zero. The response slot is empty, so `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| req_wdata | input | 32 | Write data or bit mask |
| dbg_mode | input | 1 | Hart is in debug mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Value before the access (zero if illegal) |
| rsp_illegal | output | 1 | Access raised illegal instruction |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_epc | input | 32 | Faulting or interrupted instruction address |
| trap_cause | input | 32 | Cause code, bit 31 marks interrupt |
| trap_tval | input | 32 | Exception-specific value |
| irq_ext | input | 1 | External interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_sw | input | 1 | Software interrupt line |
| plat_irq | input | 16 | Platform interrupt lines |

## Verification
The assertions assume the request payload (address, operation, data and debug flag) stays unchanged while `req_valid` is high and not yet accepted. They also assume `rsp_ready` is meaningful only while a response is pending. The stimulus drives each request on a falling edge and holds it until the model sees acceptance. Stimulus then drops the request before the next falling edge. Interrupt lines and trap inputs change only on falling edges. A trap is lined up with a request in the same cycle to exercise the priority rule.

// File: rtl/hart_csr_pkg.sv
`timescale 1ns/1ps
package hart_csr_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned PLAT_W  = 16;
  localparam int unsigned FLAGS_W = 5;
  localparam int unsigned RM_W    = 3;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_FFLAGS, SEL_FRM, SEL_FCSR,
    SEL_MSTATUS, SEL_MIE, SEL_MTVEC, SEL_MEPC,
    SEL_MCAUSE, SEL_MTVAL, SEL_MIP, SEL_DCSR,
    SEL_DPC, SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART
  } csr_sel_e;

  localparam logic [ADDR_W-1:0] A_FFLAGS  = 12'h001;
  localparam logic [ADDR_W-1:0] A_FRM     = 12'h002;
  localparam logic [ADDR_W-1:0] A_FCSR    = 12'h003;
  localparam logic [ADDR_W-1:0] A_MSTATUS = 12'h300;
  localparam logic [ADDR_W-1:0] A_MIE     = 12'h304;
  localparam logic [ADDR_W-1:0] A_MTVEC   = 12'h305;
  localparam logic [ADDR_W-1:0] A_MEPC    = 12'h341;
  localparam logic [ADDR_W-1:0] A_MCAUSE  = 12'h342;
  localparam logic [ADDR_W-1:0] A_MTVAL   = 12'h343;
  localparam logic [ADDR_W-1:0] A_MIP     = 12'h344;
  localparam logic [ADDR_W-1:0] A_DCSR    = 12'h7B0;
  localparam logic [ADDR_W-1:0] A_DPC     = 12'h7B1;
  localparam logic [ADDR_W-1:0] A_VENDOR  = 12'hF11;
  localparam logic [ADDR_W-1:0] A_ARCH    = 12'hF12;
  localparam logic [ADDR_W-1:0] A_IMPL    = 12'hF13;
  localparam logic [ADDR_W-1:0] A_HART    = 12'hF14;

  localparam int unsigned ST_MIE_BIT  = 3;
  localparam int unsigned ST_MPIE_BIT = 7;
  localparam int unsigned ST_MPP_LO   = 11;
  localparam int unsigned ST_FS_LO    = 13;
  localparam int unsigned ST_SD_BIT   = XLEN - 1;

  localparam logic [XLEN-1:0] MSTATUS_WMASK =
      (32'h1 << ST_MIE_BIT) | (32'h1 << ST_MPIE_BIT) |
      (32'h3 << ST_MPP_LO)  | (32'h3 << ST_FS_LO);

  localparam int unsigned IRQ_SW_BIT  = 3;
  localparam int unsigned IRQ_TMR_BIT = 7;
  localparam int unsigned IRQ_EXT_BIT = 11;
  localparam int unsigned PLAT_LO     = XLEN - PLAT_W;

  localparam logic [XLEN-1:0] MIE_WMASK =
      ({XLEN{1'b1}} << PLAT_LO) | (32'h1 << IRQ_EXT_BIT) |
      (32'h1 << IRQ_TMR_BIT) | (32'h1 << IRQ_SW_BIT);

  localparam logic [XLEN-1:0] MEPC_MASK = ~32'h3;
  localparam logic [XLEN-1:0] DPC_MASK  = ~32'h1;

  localparam logic [XLEN-1:0] DCSR_WMASK =
      (32'h1 << 15) | (32'h1 << 11) | (32'h1 << 10) | (32'h1 << 9) | (32'h1 << 2);
  localparam logic [1:0] DCSR_PRV_M = 2'b11;

endpackage

// File: rtl/csr_addr_decode.sv
`timescale 1ns/1ps
module csr_addr_decode
  import hart_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              dbg_mode,
  input  logic              is_write,
  output csr_sel_e          sel,
  output logic              bad_access
);

  logic known;
  logic dbg_only;
  logic read_only;

  always_comb begin
    known = 1'b1;
    sel   = SEL_NONE;
    unique case (addr)
      A_FFLAGS:  sel = SEL_FFLAGS;
      A_FRM:     sel = SEL_FRM;
      A_FCSR:    sel = SEL_FCSR;
      A_MSTATUS: sel = SEL_MSTATUS;
      A_MIE:     sel = SEL_MIE;
      A_MTVEC:   sel = SEL_MTVEC;
      A_MEPC:    sel = SEL_MEPC;
      A_MCAUSE:  sel = SEL_MCAUSE;
      A_MTVAL:   sel = SEL_MTVAL;
      A_MIP:     sel = SEL_MIP;
      A_DCSR:    sel = SEL_DCSR;
      A_DPC:     sel = SEL_DPC;
      A_VENDOR:  sel = SEL_VENDOR;
      A_ARCH:    sel = SEL_ARCH;
      A_IMPL:    sel = SEL_IMPL;
      A_HART:    sel = SEL_HART;
      default:   known = 1'b0;
    endcase
  end

  assign dbg_only   = (sel == SEL_DCSR) || (sel == SEL_DPC);
  assign read_only  = (sel == SEL_VENDOR) || (sel == SEL_ARCH) ||
                      (sel == SEL_IMPL)   || (sel == SEL_HART);
  assign bad_access = !known || (dbg_only && !dbg_mode) || (read_only && is_write);

endmodule

// File: rtl/csr_update_calc.sv
`timescale 1ns/1ps
module csr_update_calc
  import hart_csr_pkg::*;
(
  input  csr_op_e         op,
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] merged,
  output logic            is_write
);

  always_comb begin
    unique case (op)
      OP_WRITE: merged = wdata;
      OP_SET:   merged = cur | wdata;
      OP_CLEAR: merged = cur & ~wdata;
      default:  merged = cur;
    endcase
  end

  assign is_write = (op != OP_READ);

endmodule

// File: rtl/csr_state.sv
`timescale 1ns/1ps
module csr_state
  import hart_csr_pkg::*;
#(
  parameter logic [XLEN-1:0] VENDOR_ID = 32'h0000_0000,
  parameter logic [XLEN-1:0] ARCH_ID   = 32'h0000_0000,
  parameter logic [XLEN-1:0] IMPL_ID   = 32'h0000_0000,
  parameter logic [XLEN-1:0] HART_ID   = 32'h0000_0000,
  parameter logic [3:0]      DEBUG_VER = 4'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csr_sel_e          sel,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_val,
  input  logic              trap_valid,
  input  logic [XLEN-1:0]   trap_epc,
  input  logic [XLEN-1:0]   trap_cause,
  input  logic [XLEN-1:0]   trap_tval,
  input  logic              irq_ext,
  input  logic              irq_tmr,
  input  logic              irq_sw,
  input  logic [PLAT_W-1:0] plat_irq,
  output logic [XLEN-1:0]   rd_val
);

  logic [FLAGS_W-1:0] fflags_q;
  logic [RM_W-1:0]    frm_q;
  logic [XLEN-1:0]    mstatus_q;
  logic [XLEN-1:0]    mie_q;
  logic [XLEN-1:0]    mtvec_q;
  logic [XLEN-1:0]    mepc_q;
  logic [XLEN-1:0]    mcause_q;
  logic [XLEN-1:0]    mtval_q;
  logic [XLEN-1:0]    dcsr_q;
  logic [XLEN-1:0]    dpc_q;

  logic [XLEN-1:0] mstatus_view;
  logic [XLEN-1:0] mip_view;
  logic [XLEN-1:0] dcsr_view;
  logic [XLEN-1:0] fcsr_view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fflags_q  <= '0;
      frm_q     <= '0;
      mstatus_q <= '0;
      mie_q     <= '0;
      mtvec_q   <= '0;
      mepc_q    <= '0;
      mcause_q  <= '0;
      mtval_q   <= '0;
      dcsr_q    <= '0;
      dpc_q     <= '0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          SEL_FFLAGS:  fflags_q  <= wr_val[FLAGS_W-1:0];
          SEL_FRM:     frm_q     <= wr_val[RM_W-1:0];
          SEL_FCSR:    {frm_q, fflags_q} <= wr_val[FLAGS_W+RM_W-1:0];
          SEL_MSTATUS: mstatus_q <= wr_val & MSTATUS_WMASK;
          SEL_MIE:     mie_q     <= wr_val & MIE_WMASK;
          SEL_MTVEC:   mtvec_q   <= wr_val;
          SEL_MEPC:    mepc_q    <= wr_val & MEPC_MASK;
          SEL_MCAUSE:  mcause_q  <= wr_val;
          SEL_MTVAL:   mtval_q   <= wr_val;
          SEL_DCSR:    dcsr_q    <= wr_val & DCSR_WMASK;
          SEL_DPC:     dpc_q     <= wr_val & DPC_MASK;
          default:     ;
        endcase
      end
      // trap entry overrides any same-cycle software write
      if (trap_valid) begin
        mepc_q   <= trap_epc & MEPC_MASK;
        mcause_q <= trap_cause;
        mtval_q  <= trap_tval;
      end
    end
  end

  assign fcsr_view = {{(XLEN-FLAGS_W-RM_W){1'b0}}, frm_q, fflags_q};

  always_comb begin
    mstatus_view = mstatus_q;
    mstatus_view[ST_SD_BIT] = &mstatus_q[ST_FS_LO +: 2];
  end

  always_comb begin
    mip_view = '0;
    mip_view[XLEN-1:PLAT_LO] = plat_irq;
    mip_view[IRQ_EXT_BIT]    = irq_ext;
    mip_view[IRQ_TMR_BIT]    = irq_tmr;
    mip_view[IRQ_SW_BIT]     = irq_sw;
  end

  always_comb begin
    dcsr_view = dcsr_q;
    dcsr_view[XLEN-1 -: 4] = DEBUG_VER;
    dcsr_view[1:0]         = DCSR_PRV_M;
  end

  always_comb begin
    unique case (sel)
      SEL_FFLAGS:  rd_val = {{(XLEN-FLAGS_W){1'b0}}, fflags_q};
      SEL_FRM:     rd_val = {{(XLEN-RM_W){1'b0}}, frm_q};
      SEL_FCSR:    rd_val = fcsr_view;
      SEL_MSTATUS: rd_val = mstatus_view;
      SEL_MIE:     rd_val = mie_q;
      SEL_MTVEC:   rd_val = mtvec_q;
      SEL_MEPC:    rd_val = mepc_q;
      SEL_MCAUSE:  rd_val = mcause_q;
      SEL_MTVAL:   rd_val = mtval_q;
      SEL_MIP:     rd_val = mip_view;
      SEL_DCSR:    rd_val = dcsr_view;
      SEL_DPC:     rd_val = dpc_q;
      SEL_VENDOR:  rd_val = VENDOR_ID;
      SEL_ARCH:    rd_val = ARCH_ID;
      SEL_IMPL:    rd_val = IMPL_ID;
      SEL_HART:    rd_val = HART_ID;
      default:     rd_val = '0;
    endcase
  end

  // R4: the rounding-mode store never holds an encoding other than 000
  p_rm_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q == '0);

  // R5: unimplemented status bits never get stored
  p_status_wpri_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mstatus_q & ~MSTATUS_WMASK) == '0);

  // R8: trap PC stays word aligned
  p_epc_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_q[1:0] == 2'b00);

  // R9: a trap loads cause and value on the following cycle
  p_trap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (mcause_q == $past(trap_cause)) && (mtval_q == $past(trap_tval)));

  // R10: debug PC bit 0 is never set
  p_dpc_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dpc_q[0] == 1'b0);

endmodule

// File: rtl/hart_csr_bank.sv
`timescale 1ns/1ps
module hart_csr_bank
  import hart_csr_pkg::*;
#(
  parameter logic [31:0] VENDOR_ID = 32'h0000_0A5C,
  parameter logic [31:0] ARCH_ID   = 32'h0000_0005,
  parameter logic [31:0] IMPL_ID   = 32'h0001_0003,
  parameter logic [31:0] HART_ID   = 32'h0000_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [11:0] req_addr,
  input  logic [1:0]  req_op,
  input  logic [31:0] req_wdata,
  input  logic        dbg_mode,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_illegal,
  input  logic        trap_valid,
  input  logic [31:0] trap_epc,
  input  logic [31:0] trap_cause,
  input  logic [31:0] trap_tval,
  input  logic        irq_ext,
  input  logic        irq_tmr,
  input  logic        irq_sw,
  input  logic [15:0] plat_irq
);

  csr_op_e         op;
  csr_sel_e        sel;
  logic            bad_access;
  logic            is_write;
  logic [XLEN-1:0] cur_val;
  logic [XLEN-1:0] merged;
  logic            bad_rm;
  logic            illegal;
  logic            accept;
  logic            wr_en;

  assign op        = csr_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  csr_addr_decode u_decode (
    .addr       (req_addr),
    .dbg_mode   (dbg_mode),
    .is_write   (is_write),
    .sel        (sel),
    .bad_access (bad_access)
  );

  csr_update_calc u_calc (
    .op       (op),
    .cur      (cur_val),
    .wdata    (req_wdata),
    .merged   (merged),
    .is_write (is_write)
  );

  // a write leaving any rounding mode but 000 is refused
  assign bad_rm = is_write &&
                  (((sel == SEL_FRM)  && (merged[RM_W-1:0] != '0)) ||
                   ((sel == SEL_FCSR) && (merged[FLAGS_W +: RM_W] != '0)));

  assign illegal = bad_access || bad_rm;
  assign wr_en   = accept && is_write && !illegal;

  csr_state #(
    .VENDOR_ID (VENDOR_ID),
    .ARCH_ID   (ARCH_ID),
    .IMPL_ID   (IMPL_ID),
    .HART_ID   (HART_ID),
    .DEBUG_VER (4'd4)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .wr_val     (merged),
    .trap_valid (trap_valid),
    .trap_epc   (trap_epc),
    .trap_cause (trap_cause),
    .trap_tval  (trap_tval),
    .irq_ext    (irq_ext),
    .irq_tmr    (irq_tmr),
    .irq_sw     (irq_sw),
    .plat_irq   (plat_irq),
    .rd_val     (cur_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_rdata   <= illegal ? '0 : cur_val;
      rsp_illegal <= illegal;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // R1: a stalled response does not move
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_illegal));

  // R10: debug registers are refused outside debug mode
  p_dbg_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dbg_mode && (req_addr == A_DCSR || req_addr == A_DPC)
    |=> rsp_valid && rsp_illegal);

  // R11: identity words refuse any modifying operation
  p_id_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_op != 2'b00) &&
    (req_addr >= A_VENDOR) && (req_addr <= A_HART) |=> rsp_illegal);

  // R12: illegal responses carry no data
  p_illegal_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_illegal |-> rsp_rdata == '0);

endmodule

// File: tb/hart_csr_bank_tb_top.sv
`timescale 1ns/1ps
module hart_csr_bank_tb_top;

  localparam logic [31:0] VID = 32'h0000_0A5C;
  localparam logic [31:0] AID = 32'h0000_0005;
  localparam logic [31:0] IID = 32'h0001_0003;
  localparam logic [31:0] HID = 32'h0000_0002;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic        dbg_mode = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_illegal;
  logic        trap_valid = 1'b0;
  logic [31:0] trap_epc = '0, trap_cause = '0, trap_tval = '0;
  logic        irq_ext = 1'b0, irq_tmr = 1'b0, irq_sw = 1'b0;
  logic [15:0] plat_irq = '0;

  hart_csr_bank #(.VENDOR_ID(VID), .ARCH_ID(AID), .IMPL_ID(IID), .HART_ID(HID)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata), .dbg_mode(dbg_mode),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_illegal(rsp_illegal), .trap_valid(trap_valid), .trap_epc(trap_epc),
    .trap_cause(trap_cause), .trap_tval(trap_tval), .irq_ext(irq_ext),
    .irq_tmr(irq_tmr), .irq_sw(irq_sw), .plat_irq(plat_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string req_tag = "R13";

  // behavioural reference state
  int unsigned m_fflags, m_frm, m_mst, m_mie, m_tvec, m_epc, m_cause, m_tval, m_dcsr, m_dpc;
  bit          m_rsp_valid;
  int unsigned m_rdata;
  bit          m_ill;
  string       m_tag;
  bit          acc_pulse;

  task automatic model_access();
    int unsigned cur, nv;
    bit ill;
    ill = 0; cur = 0;
    case (req_addr)
      12'h001: cur = m_fflags;
      12'h002: cur = m_frm;
      12'h003: cur = (m_frm << 5) | m_fflags;
      12'h300: cur = m_mst | (((m_mst >> 13) & 3) == 3 ? 32'h8000_0000 : 0);
      12'h304: cur = m_mie;
      12'h305: cur = m_tvec;
      12'h341: cur = m_epc;
      12'h342: cur = m_cause;
      12'h343: cur = m_tval;
      12'h344: cur = (32'(plat_irq) << 16) | (32'(irq_ext) << 11) | (32'(irq_tmr) << 7) | (32'(irq_sw) << 3);
      12'h7B0: if (dbg_mode) cur = m_dcsr | 32'h4000_0003; else ill = 1;
      12'h7B1: if (dbg_mode) cur = m_dpc; else ill = 1;
      12'hF11: begin cur = VID; ill = (req_op != 0); end
      12'hF12: begin cur = AID; ill = (req_op != 0); end
      12'hF13: begin cur = IID; ill = (req_op != 0); end
      12'hF14: begin cur = HID; ill = (req_op != 0); end
      default: ill = 1;
    endcase
    if (req_op == 1) nv = req_wdata;
    else if (req_op == 2) nv = cur | req_wdata;
    else nv = cur & ~req_wdata;
    if (req_op != 0 && !ill) begin
      case (req_addr)
        12'h001: m_fflags = nv & 32'h1F;
        12'h002: if ((nv & 7) != 0) ill = 1; else m_frm = 0;
        12'h003: if (((nv >> 5) & 7) != 0) ill = 1; else m_fflags = nv & 32'h1F;
        12'h300: m_mst  = nv & 32'h0000_7888;
        12'h304: m_mie  = nv & 32'hFFFF_0888;
        12'h305: m_tvec = nv;
        12'h341: m_epc  = nv & ~32'h3;
        12'h342: m_cause = nv;
        12'h343: m_tval = nv;
        12'h7B0: m_dcsr = nv & 32'h0000_8E04;
        12'h7B1: m_dpc  = nv & ~32'h1;
        default: ;
      endcase
    end
    m_ill   = ill;
    m_rdata = ill ? 0 : cur;
    m_tag   = req_tag;
  endtask

  always @(posedge clk) begin
    acc_pulse = 0;
    if (!rst_n) begin
      m_fflags = 0; m_frm = 0; m_mst = 0; m_mie = 0; m_tvec = 0; m_epc = 0;
      m_cause = 0; m_tval = 0; m_dcsr = 0; m_dpc = 0; m_rsp_valid = 0;
      m_rdata = 0; m_ill = 0; m_tag = "R13";
    end else begin
      if (req_valid && (!m_rsp_valid || rsp_ready)) begin
        acc_pulse = 1;
        model_access();
        m_rsp_valid = 1;
      end else if (rsp_ready) begin
        m_rsp_valid = 0;
      end
      if (trap_valid) begin
        m_epc = trap_epc & ~32'h3; m_cause = trap_cause; m_tval = trap_tval;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n) begin
        chk(rsp_valid == 1'b0, "R13", "rsp_valid in reset", 32'(rsp_valid), 0);
      end else begin
        chk(req_ready == (!m_rsp_valid || rsp_ready), "R1", "req_ready",
            32'(req_ready), 32'(!m_rsp_valid || rsp_ready));
        chk(rsp_valid == m_rsp_valid, "R1", "rsp_valid", 32'(rsp_valid), 32'(m_rsp_valid));
        if (m_rsp_valid) begin
          chk(rsp_rdata == m_rdata, m_tag, "rsp_rdata", rsp_rdata, m_rdata);
          chk(rsp_illegal == m_ill, m_tag, "rsp_illegal", 32'(rsp_illegal), 32'(m_ill));
        end
      end
    end
  end

  task automatic issue(input logic [11:0] a, input logic [1:0] op,
                       input logic [31:0] w, input bit dbg, input string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_op = op; req_wdata = w; dbg_mode = dbg; req_tag = tag;
    do begin @(posedge clk); #1; end while (!acc_pulse);
    req_valid = 0;
  endtask

  task automatic trap(input logic [31:0] e, input logic [31:0] c, input logic [31:0] v);
    @(negedge clk);
    trap_valid = 1; trap_epc = e; trap_cause = c; trap_tval = v;
    @(posedge clk); #1;
    trap_valid = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R13: reset values of every register
    foreach (m_tag[i]) ; // no-op keeps loop syntax out of the way
    issue(12'h003, 0, 0, 0, "R13"); issue(12'h300, 0, 0, 0, "R13");
    issue(12'h304, 0, 0, 0, "R13"); issue(12'h341, 0, 0, 0, "R13");
    issue(12'h342, 0, 0, 0, "R13"); issue(12'h7B0, 0, 0, 1, "R13");
    issue(12'h7B1, 0, 0, 1, "R13"); issue(12'h305, 0, 0, 0, "R13");
    // R3: aliased floating-point views
    issue(12'h001, 1, 32'hFFFF_FFFF, 0, "R3");
    issue(12'h003, 0, 0, 0, "R3");
    issue(12'h002, 0, 0, 0, "R3");
    issue(12'h003, 3, 32'h0000_0005, 0, "R3");
    issue(12'h001, 0, 0, 0, "R3");
    // R4: illegal rounding modes leave the word intact
    issue(12'h003, 2, 32'h0000_0020, 0, "R4");
    issue(12'h002, 1, 32'h0000_0003, 0, "R4");
    issue(12'h003, 1, 32'h0000_00E0, 0, "R4");
    issue(12'h002, 1, 32'h0000_0000, 0, "R4");
    issue(12'h003, 0, 0, 0, "R4");
    // R5: status fields and read-only summary bit
    issue(12'h300, 1, 32'hFFFF_FFFF, 0, "R5");
    issue(12'h300, 3, 32'h0000_2000, 0, "R5");
    issue(12'h300, 2, 32'h0000_2000, 0, "R5");
    issue(12'h300, 0, 0, 0, "R5");
    // R6: interrupt-enable mask
    issue(12'h304, 1, 32'hFFFF_FFFF, 0, "R6");
    issue(12'h304, 3, 32'h0001_0008, 0, "R6");
    issue(12'h304, 0, 0, 0, "R6");
    // R7: pending reflects live lines, writes ignored
    @(negedge clk); irq_ext = 1; irq_sw = 1; plat_irq = 16'hA5C3;
    issue(12'h344, 0, 0, 0, "R7");
    issue(12'h344, 1, 32'h0000_0000, 0, "R7");
    @(negedge clk); irq_ext = 0; irq_tmr = 1; irq_sw = 0; plat_irq = 16'h0001;
    issue(12'h344, 2, 32'hFFFF_FFFF, 0, "R7");
    issue(12'h344, 0, 0, 0, "R7");
    // R2 / R8: full-width registers, read returns old value
    issue(12'h305, 1, 32'h8000_0101, 0, "R2");
    issue(12'h305, 1, 32'h0000_0200, 0, "R2");
    issue(12'h305, 0, 0, 0, "R8");
    issue(12'h341, 1, 32'hDEAD_BEEF, 0, "R8");
    issue(12'h341, 0, 0, 0, "R8");
    issue(12'h343, 1, 32'h1234_5678, 0, "R8");
    issue(12'h342, 2, 32'h8000_000B, 0, "R8");
    issue(12'h342, 0, 0, 0, "R8");
    // R9: trap entry, alone and against a same-cycle write
    trap(32'h0000_1003, 32'h0000_0002, 32'hCAFE_F00D);
    issue(12'h341, 0, 0, 0, "R9"); issue(12'h342, 0, 0, 0, "R9"); issue(12'h343, 0, 0, 0, "R9");
    fork
      issue(12'h342, 1, 32'h0000_0777, 0, "R9");
      trap(32'h0000_2000, 32'h8000_0007, 32'h0000_0042);
    join
    issue(12'h342, 0, 0, 0, "R9"); issue(12'h341, 0, 0, 0, "R9");
    // R10: debug gating and field layout
    issue(12'h7B0, 1, 32'hFFFF_FFFF, 0, "R10");
    issue(12'h7B1, 1, 32'h0000_0123, 0, "R10");
    issue(12'h7B0, 0, 0, 1, "R10");
    issue(12'h7B0, 1, 32'hFFFF_FFFF, 1, "R10");
    issue(12'h7B0, 0, 0, 1, "R10");
    issue(12'h7B1, 1, 32'h0000_0123, 1, "R10");
    issue(12'h7B1, 0, 0, 1, "R10");
    issue(12'h7B1, 0, 0, 0, "R10");
    // R11: identity words
    issue(12'hF11, 0, 0, 0, "R11"); issue(12'hF12, 0, 0, 0, "R11");
    issue(12'hF13, 0, 0, 0, "R11"); issue(12'hF14, 0, 0, 0, "R11");
    issue(12'hF14, 1, 32'h1, 0, "R11"); issue(12'hF11, 3, 32'h0, 0, "R11");
    // R12: unimplemented addresses
    issue(12'h123, 1, 32'hFFFF_FFFF, 0, "R12");
    issue(12'h7B2, 0, 0, 1, "R12");
    issue(12'h306, 1, 32'h1, 0, "R12");
    // R1: back-pressure holds the response
    @(negedge clk); rsp_ready = 0;
    fork
      begin issue(12'h305, 0, 0, 0, "R1"); issue(12'hF13, 0, 0, 0, "R1"); end
      begin repeat (5) @(negedge clk); rsp_ready = 1; end
    join
    repeat (4) @(negedge clk);
    summary();
  end

endmodule